// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by a distance taken from a register, and it produces the shifted value together with the carry bit that the shift moves out. It supports four kinds of shift: logical left, logical right, arithmetic right and rotate right. A datapath places it in front of its ALU. The ALU consumes the result as an operand and uses the carry-out when it updates its flags.

The distance is the low byte of a 32-bit amount register. The block therefore has to define its behaviour for distances from 0 up to 255. It has fixed rules for a distance of zero, for a distance equal to the operand width, and for distances beyond the operand width. Rotation reduces the distance modulo the width and applies its own carry rule when the reduced distance is zero.

The block is purely combinational. Internally it uses one right-shifting logarithmic core. A left shift is handled by bit-reversing the operand before the core and bit-reversing the result after it.

Top module: `bsh_carry_shifter`

## Requirements
- R1: Only bits [7:0] of `amt_i` select the distance. Bits [31:8] have no effect on either output.
- R2: When the distance byte is zero, `res_o` equals `val_i` and `carry_o` equals `carry_i`. This holds for every shift kind.
- R3: Kind 2'b00 is a logical left shift.
  - For a distance d from 1 to 31, the result is `val_i << d` and the carry is bit (32-d) of `val_i`.
  - For d = 32, the result is 0 and the carry is bit 0.
  - For d above 32, both the result and the carry are 0.
- R4: Kind 2'b01 is a logical right shift.
  - For d from 1 to 31, the result is `val_i >> d` and the carry is bit (d-1).
  - For d = 32, the result is 0 and the carry is bit 31.
  - For d above 32, both the result and the carry are 0.
- R5: Kind 2'b10 is an arithmetic right shift.
  - For d from 1 to 31, the result fills with copies of bit 31 and the carry is bit (d-1).
  - For d of 32 or more, every result bit equals bit 31, and so does the carry.
- R6: Kind 2'b11 is a rotate right by d modulo 32.
  - If the reduced distance is zero while d is nonzero, the result is `val_i` unchanged and the carry is bit 31.
  - Otherwise the value rotates right and the carry is bit (reduced distance - 1).
- R7: The outputs depend only on the present inputs. There is no state, and a change at the inputs shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| val_i | input | 32 | Operand to be shifted |
| amt_i | input | 32 | Amount register; only its low byte is used |
| kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions are immediate checks evaluated whenever an input changes. They assume that all inputs hold known 0/1 values, and that the distance byte is the only part of `amt_i` that can affect the outputs. The stimulus drives fully defined operands one step after each rising clock edge and compares at the falling edge, so every check sees settled inputs. The stimulus covers every distance byte from 0 to 255 for each kind, with several operand patterns. It also repeats a set of distances with random upper amount bits, which exercises the ignored field.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/bsh_amount_classify.sv
module bsh_amount_classify #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    parameter int SHW      = $clog2(WIDTH)
) (
    input  logic [AMT_BITS-1:0] amt_i,
    output logic                is_zero_o,
    output logic                is_full_o,
    output logic                is_over_o,
    output logic [SHW-1:0]      low_o,
    output logic                low_zero_o
);
    localparam logic [AMT_BITS-1:0] FULL_AMT = AMT_BITS'(WIDTH);

    assign is_zero_o  = (amt_i == '0);
    assign is_full_o  = (amt_i == FULL_AMT);
    assign is_over_o  = (amt_i > FULL_AMT);
    assign low_o      = amt_i[SHW-1:0];
    assign low_zero_o = (amt_i[SHW-1:0] == '0);
endmodule

// File: rtl/bsh_bit_reverse.sv
module bsh_bit_reverse #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_i,
    output logic [WIDTH-1:0] out_o
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev
            assign out_o[i] = in_i[WIDTH-1-i];
        end
    endgenerate
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             fill_i,
    input  logic             rot_i,
    input  logic [SHW-1:0]   dist_i,
    output logic [WIDTH-1:0] data_o,
    output logic             tap_o
);
    logic [WIDTH-1:0] stg [0:SHW];
    logic [SHW-1:0]   tap_idx;

    assign stg[0] = data_i;

    generate
        for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            logic [WIDTH-1:0] moved;
            assign moved = rot_i ? {stg[k][STEP-1:0], stg[k][WIDTH-1:STEP]}
                                 : {{STEP{fill_i}}, stg[k][WIDTH-1:STEP]};
            assign stg[k+1] = dist_i[k] ? moved : stg[k];
        end
    endgenerate

    assign data_o  = stg[SHW];
    assign tap_idx = dist_i - SHW'(1);
    assign tap_o   = data_i[tap_idx];
endmodule

// File: rtl/bsh_carry_shifter.sv
module bsh_carry_shifter
    import bsh_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int AMT_REG_W = 32,
    parameter int AMT_BITS  = 8
) (
    input  logic [WIDTH-1:0]     val_i,
    input  logic [AMT_REG_W-1:0] amt_i,
    input  logic [1:0]           kind_i,
    input  logic                 carry_i,
    output logic [WIDTH-1:0]     res_o,
    output logic                 carry_o
);
    localparam int SHW = $clog2(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             carry;
    } shout_t;

    shift_kind_e         kind;
    logic [AMT_BITS-1:0] dist_byte;
    logic                is_zero, is_full, is_over, low_zero;
    logic [SHW-1:0]      low;
    logic [WIDTH-1:0]    val_rev, core_in, core_out, core_out_rev;
    logic                core_tap, fill, rot;
    shout_t              out_d;

    assign kind      = shift_kind_e'(kind_i);
    assign dist_byte = amt_i[AMT_BITS-1:0];

    bsh_amount_classify #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS), .SHW(SHW)) u_classify (
        .amt_i      (dist_byte),
        .is_zero_o  (is_zero),
        .is_full_o  (is_full),
        .is_over_o  (is_over),
        .low_o      (low),
        .low_zero_o (low_zero)
    );

    bsh_bit_reverse #(.WIDTH(WIDTH)) u_rev_in (
        .in_i  (val_i),
        .out_o (val_rev)
    );

    assign core_in = (kind == SHK_LSL) ? val_rev : val_i;
    assign fill    = (kind == SHK_ASR) ? val_i[WIDTH-1] : 1'b0;
    assign rot     = (kind == SHK_ROR);

    bsh_shift_core #(.WIDTH(WIDTH), .SHW(SHW)) u_core (
        .data_i (core_in),
        .fill_i (fill),
        .rot_i  (rot),
        .dist_i (low),
        .data_o (core_out),
        .tap_o  (core_tap)
    );

    bsh_bit_reverse #(.WIDTH(WIDTH)) u_rev_out (
        .in_i  (core_out),
        .out_o (core_out_rev)
    );

    always_comb begin
        out_d.value = core_out;
        out_d.carry = core_tap;
        if (is_zero) begin
            out_d.value = val_i;
            out_d.carry = carry_i;
        end else begin
            unique case (kind)
                SHK_LSL: begin
                    if (is_full) begin
                        out_d.value = '0;
                        out_d.carry = val_i[0];
                    end else if (is_over) begin
                        out_d.value = '0;
                        out_d.carry = 1'b0;
                    end else begin
                        out_d.value = core_out_rev;
                        out_d.carry = core_tap;
                    end
                end
                SHK_LSR: begin
                    if (is_full) begin
                        out_d.value = '0;
                        out_d.carry = val_i[WIDTH-1];
                    end else if (is_over) begin
                        out_d.value = '0;
                        out_d.carry = 1'b0;
                    end
                end
                SHK_ASR: begin
                    if (is_full || is_over) begin
                        out_d.value = {WIDTH{val_i[WIDTH-1]}};
                        out_d.carry = val_i[WIDTH-1];
                    end
                end
                SHK_ROR: begin
                    if (low_zero) begin
                        out_d.value = val_i;
                        out_d.carry = val_i[WIDTH-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign res_o   = out_d.value;
    assign carry_o = out_d.carry;
endmodule

module bsh_carry_shifter_chk #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8
) (
    input logic [WIDTH-1:0]    val_i,
    input logic [AMT_BITS-1:0] amt_lo,
    input logic [1:0]          kind_i,
    input logic                carry_i,
    input logic [WIDTH-1:0]    res_o,
    input logic                carry_o
);
    localparam logic [AMT_BITS-1:0] FULL_AMT = AMT_BITS'(WIDTH);
    localparam int SHW = $clog2(WIDTH);

    always_comb begin
        if (amt_lo == '0)
            p_zero_pass_r2: assert (res_o == val_i && carry_o == carry_i);
        if (kind_i == 2'b00 && amt_lo > FULL_AMT)
            p_lsl_over_r3: assert (res_o == '0 && carry_o == 1'b0);
        if (kind_i == 2'b00 && amt_lo == FULL_AMT)
            p_lsl_full_r3: assert (res_o == '0 && carry_o == val_i[0]);
        if (kind_i == 2'b01 && amt_lo >= FULL_AMT)
            p_lsr_clear_r4: assert (res_o == '0);
        if (kind_i == 2'b10 && amt_lo >= FULL_AMT)
            p_asr_sign_r5: assert (res_o == {WIDTH{val_i[WIDTH-1]}} && carry_o == val_i[WIDTH-1]);
        if (kind_i == 2'b11 && amt_lo != '0 && amt_lo[SHW-1:0] == '0)
            p_ror_wrap_r6: assert (res_o == val_i && carry_o == val_i[WIDTH-1]);
    end
endmodule

bind bsh_carry_shifter bsh_carry_shifter_chk #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_chk (
    .val_i   (val_i),
    .amt_lo  (amt_i[AMT_BITS-1:0]),
    .kind_i  (kind_i),
    .carry_i (carry_i),
    .res_o   (res_o),
    .carry_o (carry_o)
);

// File: tb/bsh_carry_shifter_tb.sv
module bsh_carry_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] val;
    logic [31:0] amt;
    logic [1:0]  kind;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bsh_carry_shifter u_dut (
        .val_i   (val),
        .amt_i   (amt),
        .kind_i  (kind),
        .carry_i (cin),
        .res_o   (res),
        .carry_o (cout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [32:0] ref_model(logic [31:0] v, logic [31:0] a,
                                              logic [1:0] k, logic c);
        int n;
        int m;
        logic [63:0] t;
        logic [31:0] r;
        n = int'(a[7:0]);
        if (n == 0) return {c, v};
        case (k)
            2'b00: begin
                t = {32'b0, v} << n;
                return {t[32], t[31:0]};
            end
            2'b01: begin
                t = {v, 32'b0} >> n;
                return {t[31], t[63:32]};
            end
            2'b10: begin
                if (n >= 32) return {v[31], {32{v[31]}}};
                t = $signed({v, 32'b0}) >>> n;
                return {t[31], t[63:32]};
            end
            default: begin
                m = n % 32;
                if (m == 0) return {v[31], v};
                r = (v >> m) | (v << (32 - m));
                return {v[m-1], r};
            end
        endcase
    endfunction

    function automatic string kind_tag(logic [1:0] k, logic [7:0] d);
        if (d == 8'd0) return "R2";
        case (k)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [32:0] got, logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: kind=%b amt=%h val=%h actual {c,res}=%h expected %h",
                     tag, kind, amt, val, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] v, logic [31:0] a, logic [1:0] k, logic c);
        @(posedge clk);
        #1;
        val  = v;
        amt  = a;
        kind = k;
        cin  = c;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] pats [4];
        logic [32:0] base;
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h1234_5678;
        pats[2] = 32'hFEDC_BA98;
        pats[3] = 32'h7FFF_FFFE;
        val = '0; amt = '0; kind = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all-zero inputs give zero outputs (R2)
        check("R2", {cout, res}, 33'h0);

        // Full sweep of every distance byte for every kind (R2..R6)
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int d = 0; d < 256; d++) begin
                    apply(pats[p], 32'(d), 2'(k), p[0]);
                    check(kind_tag(2'(k), 8'(d)), {cout, res},
                          ref_model(pats[p], 32'(d), 2'(k), p[0]));
                end
            end
        end

        // Corner values named by the requirements
        apply(32'h0000_0001, 32'd32, 2'b00, 1'b0);
        check("R3", {cout, res}, {1'b1, 32'h0});
        apply(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
        check("R3", {cout, res}, 33'h0);
        apply(32'h8000_0000, 32'd32, 2'b01, 1'b0);
        check("R4", {cout, res}, {1'b1, 32'h0});
        apply(32'hFFFF_FFFF, 32'd200, 2'b01, 1'b1);
        check("R4", {cout, res}, 33'h0);
        apply(32'h8000_0000, 32'd255, 2'b10, 1'b0);
        check("R5", {cout, res}, {1'b1, 32'hFFFF_FFFF});
        apply(32'h8000_0000, 32'd64, 2'b11, 1'b0);
        check("R6", {cout, res}, {1'b1, 32'h8000_0000});
        apply(32'h0000_0003, 32'd33, 2'b11, 1'b0);
        check("R6", {cout, res}, {1'b1, 32'h8000_0001});
        apply(32'hDEAD_BEEF, 32'd0, 2'b11, 1'b1);
        check("R2", {cout, res}, {1'b1, 32'hDEAD_BEEF});

        // R1: upper amount bits are ignored
        for (int i = 0; i < 400; i++) begin
            logic [31:0] v;
            logic [7:0]  d;
            logic [1:0]  k;
            v = $urandom;
            d = 8'($urandom);
            k = 2'($urandom);
            base = ref_model(v, {24'h0, d}, k, 1'b1);
            apply(v, {24'($urandom) | 24'h1, d}, k, 1'b1);
            check("R1", {cout, res}, base);
        end

        // R7: outputs follow inputs with no clock edge
        apply(32'h0000_00F0, 32'd4, 2'b01, 1'b0);
        #1;
        val = 32'h0000_0F00;
        #1;
        check("R7", {cout, res}, {1'b0, 32'h0000_00F0});
        kind = 2'b00;
        #1;
        check("R7", {cout, res}, {1'b0, 32'h0000_F000});

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule